// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of an SPI master. It accepts one word at a time from a transmit queue through a valid/ready port. It shifts the word out on a single data line while it shifts a word in from the other line, and it hands the received word to an output queue through a second valid/ready port. Timing comes from a programmable divider, so the serial clock runs at the module clock divided by 2*(div+1).

The configuration inputs are the word length (coded as length minus one), the clock polarity, and a phase bit whose sense is inverted against the usual CPHA convention. They also select the clock level shown between words, the bit order, an internal loopback and separate switches that turn the transmitter and receiver off. The `busy` output stays high until the last bit of the current word has been shifted. This is still true after the transmit queue has emptied, so it can be used to tell when the line is quiet. If no new word is waiting when a word finishes, the engine stops between words with the clock at the idle level. It never stops inside a word.

Top module: `spi_shift_master`

## Requirements
- R1: After reset `busy` and `rx_valid` are low, `sck` equals `idle_lvl` and `tx_ready` is high while `tx_off` is low.
- R2: Each half period of `sck` lasts `baud_div`+1 module clocks. A single word of N bits keeps `busy` high for exactly 2*N*(`baud_div`+1) cycles.
- R3: `word_len_m1` holds N-1, and exactly N bits are shifted. The received word is right-justified with its upper bits zero. Transmit bits above bit N-1 are not sent.
- R4: While shifting, `sck` starts at `cpol`. With `lead_sample`=1 (CPHA 0) data is captured on the first edge of each bit. With `lead_sample`=0 (CPHA 1) it is captured on the second edge.
- R5: Whenever `busy` is low, `sck` equals `idle_lvl`, which may differ from `cpol`.
- R6: With `msb_first`=1 bit N-1 goes first on both lines. With `msb_first`=0 bit 0 goes first.
- R7: With `loopback`=1 the received word equals the transmitted word and `miso` is ignored.
- R8: While `tx_off`=1, `tx_ready` is low, no word is taken and the engine stays idle.
- R9: While `rx_off`=1, words are still shifted but `rx_valid` never rises.
- R10: A word offered before the current one ends starts with no gap, and `busy` stays high until the last bit of the last word even when `tx_valid` is already low.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_data` holds. A following word that completes in that state is held at its final phase with `busy` high until the output is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIVW | Half-period divider; half period = baud_div+1 clocks |
| word_len_m1 | input | LW | Bits per word minus one |
| cpol | input | 1 | Clock polarity while shifting |
| lead_sample | input | 1 | 1: capture on leading edge; 0: capture on trailing edge |
| idle_lvl | input | 1 | Clock level while not shifting |
| msb_first | input | 1 | 1: most significant bit first |
| loopback | input | 1 | Route transmit line to the receive side internally |
| tx_off | input | 1 | Stop taking transmit words |
| rx_off | input | 1 | Discard received words |
| tx_data | input | DW | Transmit word, right-justified |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Engine takes the word on this clock |
| rx_data | output | DW | Received word, right-justified |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is being shifted or held |

## Verification
Completing a word, taking the next transmit word and pushing the finished received word can all happen on the same clock while the consumer also pops the previous received word. The bench causes this by offering two loopback words back to back with `rx_ready` held high. It judges the result by checking that the busy time equals exactly two word times with no gap, and that both received words arrive in order. A second run holds `rx_ready` low, so the push collides with a full output register. There the bench checks that the first word is kept, the engine waits with `busy` high, and nothing is lost once the consumer resumes.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DW   = 32,
  parameter int LW   = $clog2(DW),
  parameter int DIVW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] baud_div,
  input  logic [LW-1:0]   word_len_m1,
  input  logic            cpol,
  input  logic            lead_sample,
  input  logic            idle_lvl,
  input  logic            msb_first,
  input  logic            loopback,
  input  logic            tx_off,
  input  logic            rx_off,
  input  logic [DW-1:0]   tx_data,
  input  logic            tx_valid,
  output logic            tx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            busy
);
  localparam int PW = LW + 1;

  logic            active;
  logic [DIVW-1:0] hcnt;
  logic [PW-1:0]   ph;
  logic [DW-1:0]   txw, rxw;
  logic [LW-1:0]   bit_no, idx;
  logic            phase_end, word_end, stall, done, take;

  assign bit_no    = ph[PW-1:1];
  assign idx       = msb_first ? word_len_m1 - bit_no : bit_no;
  assign phase_end = active && (hcnt == baud_div);
  assign word_end  = phase_end && (ph == {word_len_m1, 1'b1});
  assign stall     = word_end && !rx_off && rx_valid && !rx_ready;
  assign done      = word_end && !stall;
  assign tx_ready  = !tx_off && (!active || done);
  assign take      = tx_valid && tx_ready;
  assign busy      = active;
  assign sck       = active ? (cpol ^ ph[0] ^ !lead_sample) : idle_lvl;
  assign mosi      = active & txw[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      hcnt     <= '0;
      ph       <= '0;
      txw      <= '0;
      rxw      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (take) begin
        active <= 1'b1;
        hcnt   <= '0;
        ph     <= '0;
        txw    <= tx_data;
        rxw    <= '0;
      end else if (done) begin
        active <= 1'b0;
      end else if (phase_end && !stall) begin
        hcnt <= '0;
        ph   <= ph + 1'b1;
      end else if (active && !stall) begin
        hcnt <= hcnt + 1'b1;
      end

      if (phase_end && !ph[0])
        rxw[idx] <= loopback ? mosi : miso;

      if (done && !rx_off) begin
        rx_data  <= rxw;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_off,
  input logic          rx_off,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          busy,
  input logic          sck,
  input logic          idle_lvl
);
  AST_TXOFF_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n) tx_off |-> !tx_ready); // R8
  AST_RXOFF_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (rx_off && !rx_valid) |=> !rx_valid); // R9
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R11
  AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> busy); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sck == idle_lvl)); // R5
endmodule

bind spi_shift_master spi_shift_master_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_spi_shift_master.sv
`timescale 1ns/1ps
module test_spi_shift_master;
  typedef struct packed {
    logic [4:0]  wl;
    logic        pol;
    logic        lead;
    logic        msb;
    logic        lb;
    logic [15:0] div;
    logic [31:0] tx;
    logic [31:0] sw;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{5'd7,  1'b0, 1'b1, 1'b1, 1'b0, 16'd0, 32'h000000A5, 32'h0000003C},
    '{5'd7,  1'b0, 1'b0, 1'b1, 1'b0, 16'd1, 32'h00000096, 32'h000000C3},
    '{5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 16'd2, 32'h0000001E, 32'h00000081},
    '{5'd7,  1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 32'h0000007F, 32'h00000001},
    '{5'd15, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0, 32'h0000BEEF, 32'h00001234},
    '{5'd31, 1'b1, 1'b0, 1'b1, 1'b0, 16'd0, 32'hDEADBEEF, 32'hCAFEF00D},
    '{5'd1,  1'b0, 1'b1, 1'b1, 1'b1, 16'd3, 32'h00000002, 32'h00000001},
    '{5'd4,  1'b0, 1'b0, 1'b0, 1'b1, 16'd0, 32'hFFFFFFEB, 32'h00000015}
  };

  logic        clk = 0, rst_n = 0;
  logic [15:0] baud_div = 0;
  logic [4:0]  word_len_m1 = 5'd7;
  logic        cpol = 0, lead_sample = 1, idle_lvl = 0, msb_first = 1, loopback = 0;
  logic        tx_off = 0, rx_off = 0;
  logic [31:0] tx_data = 0;
  logic        tx_valid = 0, tx_ready;
  logic [31:0] rx_data;
  logic        rx_valid, rx_ready = 1;
  logic        sck, mosi, miso = 0, busy;

  int checks = 0, fails = 0;
  int ecnt = 0, bcyc = 0, nrx = 0, nbits = 8;
  logic [31:0] cap = 0, sw = 0;
  logic [31:0] rxs [0:3];
  logic prev_sck = 0;

  always #2 clk = ~clk;

  spi_shift_master i_spi_shift_master (.*);

  function automatic logic [31:0] lmask(input int n);
    logic [63:0] m;
    m = (64'h1 << n) - 64'h1;
    return m[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clr();
    ecnt = 0; bcyc = 0; nrx = 0; cap = 0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    tx_data = w;
    tx_valid = 1;
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic release_tx();
    @(negedge clk);
    tx_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (busy && sck != prev_sck && sck == (lead_sample ? !cpol : cpol)) begin
      if (ecnt < nbits) cap[msb_first ? nbits - 1 - ecnt : ecnt] = mosi;
      ecnt++;
    end
    prev_sck = sck;
    if (busy) bcyc++;
    miso = (ecnt < nbits) ? sw[msb_first ? nbits - 1 - ecnt : ecnt] : 1'b0;
    if (rx_valid && rx_ready) begin
      if (nrx < 4) rxs[nrx] = rx_data;
      nrx++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy", {31'b0, busy}, 0);
    chk(rx_valid == 0, "R1", "rx_valid", {31'b0, rx_valid}, 0);
    chk(sck == idle_lvl, "R1", "sck", {31'b0, sck}, {31'b0, idle_lvl});
    chk(tx_ready == 1, "R1", "tx_ready", {31'b0, tx_ready}, 1);

    // vector table: R2 R3 R4 R6 R7
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      word_len_m1 = VECS[v].wl; cpol = VECS[v].pol; idle_lvl = VECS[v].pol;
      lead_sample = VECS[v].lead; msb_first = VECS[v].msb; loopback = VECS[v].lb;
      baud_div = VECS[v].div; sw = VECS[v].sw; nbits = int'(VECS[v].wl) + 1;
      prev_sck = sck;
      clr();
      push(VECS[v].tx);
      release_tx();
      wait_idle();
      chk(nrx == 1 && rxs[0] == (VECS[v].lb ? (VECS[v].tx & lmask(nbits)) : VECS[v].sw),
          VECS[v].lb ? "R7" : "R3/R6", "rx word", rxs[0],
          VECS[v].lb ? (VECS[v].tx & lmask(nbits)) : VECS[v].sw);
      chk(cap == (VECS[v].tx & lmask(nbits)), "R4", "serial out", cap, VECS[v].tx & lmask(nbits));
      chk(ecnt == nbits, "R3", "sample edges", ecnt, nbits);
      chk(bcyc == 2 * nbits * (int'(VECS[v].div) + 1), "R2", "busy cycles", bcyc,
          2 * nbits * (int'(VECS[v].div) + 1));
    end

    // R5 idle level distinct from polarity
    @(negedge clk);
    word_len_m1 = 5'd7; cpol = 0; lead_sample = 1; msb_first = 1; loopback = 1; baud_div = 0;
    idle_lvl = 1;
    @(negedge clk);
    chk(sck == 1, "R5", "sck idle high", {31'b0, sck}, 1);
    idle_lvl = 0;
    @(negedge clk);
    chk(sck == 0, "R5", "sck idle low", {31'b0, sck}, 0);

    // R8 transmitter off
    tx_off = 1; tx_valid = 1; tx_data = 32'h55;
    clr();
    repeat (20) @(negedge clk);
    chk(bcyc == 0, "R8", "busy cycles with tx off", bcyc, 0);
    chk(tx_ready == 0, "R8", "tx_ready", {31'b0, tx_ready}, 0);
    tx_valid = 0; tx_off = 0;

    // R9 receiver off
    rx_off = 1; nbits = 8; prev_sck = sck;
    clr();
    push(32'h3C);
    release_tx();
    wait_idle();
    chk(nrx == 0 && rx_valid == 0, "R9", "rx words with rx off", nrx, 0);
    chk(cap == 32'h3C, "R9", "serial out with rx off", cap, 32'h3C);
    rx_off = 0;

    // R10 back to back, busy after queue empty
    rx_ready = 1;
    clr();
    push(32'hA1);
    push(32'h5E);
    release_tx();
    chk(busy == 1, "R10", "busy after queue empty", {31'b0, busy}, 1);
    wait_idle();
    chk(bcyc == 32, "R10", "busy cycles two words", bcyc, 32);
    chk(nrx == 2 && rxs[0] == 32'hA1 && rxs[1] == 32'h5E, "R10", "two words",
        {rxs[0][15:0], rxs[1][15:0]}, 32'h00A1005E);

    // R11 output backpressure
    @(negedge clk);
    rx_ready = 0;
    clr();
    push(32'h11);
    push(32'h22);
    release_tx();
    repeat (100) @(negedge clk);
    chk(rx_valid == 1 && rx_data == 32'h11, "R11", "held word", rx_data, 32'h11);
    chk(busy == 1, "R11", "stalled busy", {31'b0, busy}, 1);
    rx_ready = 1;
    wait_idle();
    chk(nrx == 2 && rxs[0] == 32'h11 && rxs[1] == 32'h22, "R11", "words after release",
        {rxs[0][15:0], rxs[1][15:0]}, 32'h00110022);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule